// File: doc/BRIEF.md
# UART interrupt identification unit

This block gathers the interrupt causes of a 16550-style serial port that also has an automatic baud-rate detector. It ranks the classic causes by priority and builds a 32-bit identification word. Bit 0 of the word is an active-low "something pending" flag. Bits 3:1 carry a code for the most urgent enabled cause. Two sticky auto-baud flags sit in bits 9:8. A single interrupt request line is driven alongside the word.

The word is registered. While the bus holds the read strobe high, the word is frozen. Anything that happens during the read is kept and shows up once the strobe drops. The transmit-empty cause is an event. It is latched, and it is acknowledged by a read that returns its code. The auto-baud flags are cleared only by their own clear pulses.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the word reads 0x00000001 and `irq` is low.
- R2: Bit 0 is 0 when at least one enabled classic cause is pending and 1 otherwise. When bit 0 is 1, bits 3:1 read 000.
- R3: Each cause has its own code in bits 3:1 and its own enable. Line status error is 011 with `en_ls`. Receive data available is 010 and character time-out is 110, both with `en_rx`. Transmit empty is 001 with `en_tx`. Modem change is 000 with `en_modem`. The codes 100, 101 and 111 never appear.
- R4: When several causes are pending, the code shown is the first in this order: line status, receive data, character time-out, transmit empty, modem change.
- R5: The word takes the state present at a clock edge one cycle later. At an edge where `rd_strobe` is high, the word holds its value.
- R6: A cause or auto-baud event that appears while `rd_strobe` is high is not lost. It is reported in the word after the strobe falls.
- R7: A `tx_empty_evt` pulse latches a pending transmit-empty cause. It is cleared when a read begins (the first cycle of `rd_strobe`) and the word shows code 001 with bit 0 low. An event in that same cycle keeps it pending.
- R8: Bit 8 is set by `ab_done_evt` and bit 9 by `ab_tmo_evt`. Each flag is set only while its enable (`en_ab_done`, `en_ab_tmo`) is high.
- R9: Each auto-baud flag stays set until its clear pulse (`ab_done_clr`, `ab_tmo_clr`). A read does not clear it. A set and a clear in the same cycle leave the flag set.
- R10: Bits 7 and 6 both equal `fifo_on`. Bits 5:4 and 31:10 read 0.
- R11: `irq` is high in the same cycle whenever an enabled classic cause is pending or either auto-baud flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ls_err | input | 1 | Line status error condition (level) |
| rx_avail | input | 1 | Receive data available condition (level) |
| rx_tmo | input | 1 | Character time-out condition (level) |
| tx_empty_evt | input | 1 | Transmit holding register became empty (pulse) |
| modem_chg | input | 1 | Modem status change condition (level) |
| ab_done_evt | input | 1 | Auto-baud finished (pulse) |
| ab_tmo_evt | input | 1 | Auto-baud timed out (pulse) |
| en_rx | input | 1 | Enable for receive data and character time-out |
| en_tx | input | 1 | Enable for transmit empty |
| en_ls | input | 1 | Enable for line status |
| en_modem | input | 1 | Enable for modem change |
| en_ab_done | input | 1 | Enable for auto-baud finished flag |
| en_ab_tmo | input | 1 | Enable for auto-baud time-out flag |
| fifo_on | input | 1 | FIFO enable, mirrored into bits 7:6 |
| rd_strobe | input | 1 | High while the word is being read |
| ab_done_clr | input | 1 | Clears the auto-baud finished flag |
| ab_tmo_clr | input | 1 | Clears the auto-baud time-out flag |
| iir_word | output | 32 | Identification word |
| irq | output | 1 | Interrupt request |

## Verification
Each cause is first driven alone, with its enable on and then off. This separates a wrong code from a wrong enable mapping. Overlapping sets of causes follow, and each one then drops out in turn. These patterns show whether the priority chain is ordered correctly, including receive data against time-out inside level 2. Multi-cycle reads receive new causes, transmit-empty pulses and auto-baud events while the strobe is high. These cases tell apart a word that is truly frozen, one that loses events and one that acknowledges the wrong cause. Set and clear pulses on the auto-baud flags, alone and in the same cycle, check that the flags are sticky and that the set wins.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ls_err,
  input  logic        rx_avail,
  input  logic        rx_tmo,
  input  logic        tx_empty_evt,
  input  logic        modem_chg,
  input  logic        ab_done_evt,
  input  logic        ab_tmo_evt,
  input  logic        en_rx,
  input  logic        en_tx,
  input  logic        en_ls,
  input  logic        en_modem,
  input  logic        en_ab_done,
  input  logic        en_ab_tmo,
  input  logic        fifo_on,
  input  logic        rd_strobe,
  input  logic        ab_done_clr,
  input  logic        ab_tmo_clr,
  output logic [31:0] iir_word,
  output logic        irq
);

  localparam logic [2:0] CODE_LS    = 3'b011;
  localparam logic [2:0] CODE_RX    = 3'b010;
  localparam logic [2:0] CODE_TMO   = 3'b110;
  localparam logic [2:0] CODE_TX    = 3'b001;
  localparam logic [2:0] CODE_MODEM = 3'b000;

  logic tx_pend, ab_done_q, ab_tmo_q, rd_q;
  logic [2:0] code;

  wire act_ls    = ls_err & en_ls;
  wire act_rx    = rx_avail & en_rx;
  wire act_tmo   = rx_tmo & en_rx;
  wire act_tx    = tx_pend & en_tx;
  wire act_modem = modem_chg & en_modem;
  wire any_act   = act_ls | act_rx | act_tmo | act_tx | act_modem;

  always_comb begin
    if (act_ls)       code = CODE_LS;
    else if (act_rx)  code = CODE_RX;
    else if (act_tmo) code = CODE_TMO;
    else if (act_tx)  code = CODE_TX;
    else              code = CODE_MODEM;
  end

  wire [31:0] live_word = {22'd0, ab_tmo_q, ab_done_q, {2{fifo_on}}, 2'b00, code, ~any_act};

  wire rd_first = rd_strobe & ~rd_q;
  wire tx_ack   = rd_first & ~iir_word[0] & (iir_word[3:1] == CODE_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_word  <= 32'h0000_0001;
      rd_q      <= 1'b0;
      tx_pend   <= 1'b0;
      ab_done_q <= 1'b0;
      ab_tmo_q  <= 1'b0;
    end else begin
      if (!rd_strobe) iir_word <= live_word;
      rd_q      <= rd_strobe;
      tx_pend   <= tx_empty_evt | (tx_pend & ~tx_ack);
      ab_done_q <= (ab_done_evt & en_ab_done) | (ab_done_q & ~ab_done_clr);
      ab_tmo_q  <= (ab_tmo_evt & en_ab_tmo) | (ab_tmo_q & ~ab_tmo_clr);
    end
  end

  assign irq = any_act | ab_done_q | ab_tmo_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_strobe,
  input logic        ab_done_evt,
  input logic        en_ab_done,
  input logic        ab_done_clr,
  input logic        ab_done_q,
  input logic        ab_tmo_q,
  input logic [31:0] iir_word,
  input logic        irq
);

  // R2
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_word[0] |-> (iir_word[3:1] == 3'b000));

  // R3
  no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iir_word[3:1] inside {3'b100, 3'b101, 3'b111}));

  // R5
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_strobe) |-> $stable(iir_word));

  // R8
  done_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_done_q) |-> $past(ab_done_evt & en_ab_done));

  // R9
  done_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_done_q) |-> $past(ab_done_clr));

  // R11
  flag_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_done_q | ab_tmo_q) |-> irq);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
  .ab_done_evt(ab_done_evt), .en_ab_done(en_ab_done), .ab_done_clr(ab_done_clr),
  .ab_done_q(ab_done_q), .ab_tmo_q(ab_tmo_q), .iir_word(iir_word), .irq(irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic clk = 0, rst_n = 0;
  logic ls_err = 0, rx_avail = 0, rx_tmo = 0, tx_empty_evt = 0, modem_chg = 0;
  logic ab_done_evt = 0, ab_tmo_evt = 0;
  logic en_rx = 0, en_tx = 0, en_ls = 0, en_modem = 0, en_ab_done = 0, en_ab_tmo = 0;
  logic fifo_on = 0, rd_strobe = 0, ab_done_clr = 0, ab_tmo_clr = 0;
  logic [31:0] iir_word;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  logic [31:0] m_word = 32'h1;
  bit m_tx = 0, m_done = 0, m_tmo = 0, m_rdq = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_dut (.*);

  function automatic logic [31:0] ref_word();
    logic [31:0] w;
    w = 32'h1;
    if (ls_err && en_ls)           w = 32'h6;
    else if (rx_avail && en_rx)    w = 32'h4;
    else if (rx_tmo && en_rx)      w = 32'hC;
    else if (m_tx && en_tx)        w = 32'h2;
    else if (modem_chg && en_modem) w = 32'h0;
    if (fifo_on) w = w | 32'hC0;
    if (m_done)  w = w | 32'h100;
    if (m_tmo)   w = w | 32'h200;
    return w;
  endfunction

  function automatic bit ref_irq();
    return (ls_err && en_ls) || ((rx_avail || rx_tmo) && en_rx) || (m_tx && en_tx)
        || (modem_chg && en_modem) || m_done || m_tmo;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 32'h1; m_tx = 0; m_done = 0; m_tmo = 0; m_rdq = 0;
    end else begin
      logic [31:0] live;
      bit ack;
      live = ref_word();
      ack = rd_strobe && !m_rdq && (m_word[3:0] == 4'h2);
      if (!rd_strobe) m_word = live;
      if (ack) m_tx = tx_empty_evt;
      else     m_tx = m_tx || tx_empty_evt;
      if (ab_done_evt && en_ab_done) m_done = 1;
      else if (ab_done_clr)          m_done = 0;
      if (ab_tmo_evt && en_ab_tmo)   m_tmo = 1;
      else if (ab_tmo_clr)           m_tmo = 0;
      m_rdq = rd_strobe;
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    check(tag, iir_word, m_word);
    check("R11", {31'd0, irq}, {31'd0, ref_irq()});
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic expect_now(string t, logic [31:0] exp);
    @(negedge clk);
    check(t, iir_word, exp);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_now("R1", 32'h1);
    rst_n = 1;
    step(2);

    tag = "R10"; fifo_on = 1; step(2);
    expect_now("R10", 32'hC1);

    tag = "R3"; ls_err = 1; step(2);
    expect_now("R3 disabled ls R2", 32'hC1);
    en_ls = 1; step(2);
    expect_now("R3 ls", 32'hC6);
    ls_err = 0; en_rx = 1; rx_avail = 1; step(2);
    expect_now("R3 rx", 32'hC4);
    rx_avail = 0; rx_tmo = 1; step(2);
    expect_now("R3 tmo", 32'hCC);
    rx_tmo = 0; modem_chg = 1; step(2);
    expect_now("R3 modem disabled R2", 32'hC1);
    en_modem = 1; step(2);
    expect_now("R3 modem", 32'hC0);

    tag = "R4"; fifo_on = 0; en_tx = 1;
    tx_empty_evt = 1; step(); tx_empty_evt = 0;
    ls_err = 1; rx_avail = 1; rx_tmo = 1; step(2);
    expect_now("R4 all", 32'h6);
    ls_err = 0; step(2);
    expect_now("R4 rx over tmo", 32'h4);
    rx_avail = 0; step(2);
    expect_now("R4 tmo over tx", 32'hC);
    rx_tmo = 0; step(2);
    expect_now("R4 tx over modem", 32'h2);

    tag = "R7"; rd_strobe = 1; step(); rd_strobe = 0; step(2);
    expect_now("R7 tx acked", 32'h0);
    modem_chg = 0; step(2);
    tx_empty_evt = 1; step(); tx_empty_evt = 0; step(2);
    expect_now("R7 rearm", 32'h2);
    rd_strobe = 1; tx_empty_evt = 1; step(); tx_empty_evt = 0; rd_strobe = 0; step(2);
    expect_now("R7 same-cycle event", 32'h2);
    rd_strobe = 1; step(); rd_strobe = 0; step(2);
    expect_now("R7 cleared", 32'h1);

    tag = "R5"; rx_avail = 1; step(2);
    rd_strobe = 1; step(); ls_err = 1; step();
    expect_now("R5 frozen", 32'h4);
    tag = "R6"; tx_empty_evt = 1; ab_done_evt = 1; en_ab_done = 1; step();
    tx_empty_evt = 0; ab_done_evt = 0; step();
    expect_now("R6 still frozen R5", 32'h4);
    rd_strobe = 0; step(2);
    expect_now("R6 after read", 32'h106);
    ls_err = 0; rx_avail = 0; step(2);
    expect_now("R6 tx kept", 32'h102);

    tag = "R8"; ab_tmo_evt = 1; step(); ab_tmo_evt = 0; step(2);
    expect_now("R8 tmo disabled", 32'h102);
    en_ab_tmo = 1; ab_tmo_evt = 1; step(); ab_tmo_evt = 0; step(2);
    expect_now("R8 tmo set", 32'h302);

    tag = "R9"; en_tx = 0; rd_strobe = 1; step(2); rd_strobe = 0; step(2);
    expect_now("R9 read keeps flags", 32'h301);
    ab_done_clr = 1; step(); ab_done_clr = 0; step(2);
    expect_now("R9 done cleared", 32'h201);
    ab_tmo_clr = 1; ab_tmo_evt = 1; step(); ab_tmo_clr = 0; ab_tmo_evt = 0; step(2);
    expect_now("R9 set wins", 32'h201);
    ab_tmo_clr = 1; step(); ab_tmo_clr = 0; step(2);
    expect_now("R9 tmo cleared", 32'h1);

    tag = "R11"; en_ls = 0; ls_err = 1; step(2);
    expect_now("R11 idle", 32'h1);
    ls_err = 0; step(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule